// File: doc/BRIEF.md
# Software Write-Protect Sequence Gate

This block sits between the byte-load capture logic of a sector-programmed flash array and its program controller. Each captured write (address and data) is presented for one clock on the load inputs, and the capture logic flags the end of a load window when its inactivity timer expires. The gate looks for a three-write unlock prefix and a six-write disable sequence in that stream. It keeps a protect-enabled bit that survives reset and decides, per write and per window, whether data reaches the program controller.

While protection is off, every data write is forwarded. While it is on, a window must open with the unlock prefix, or its data is held back. The window still ends in a busy cycle, but that cycle is flagged as a dummy so the array is left unchanged while status reads run for the full cycle time. Command writes that match a sequence step are swallowed and never reach the array.

Top module: `swp_gate`

## Requirements
- R1: After power-up the protect bit is 0 (`prot_on_o` low), and while `rst_ni` is low `fwd_valid_o`, `cycle_start_o` and `cycle_dummy_o` are 0.
- R2: With protection off, a data write on `load_valid_i` appears on `fwd_valid_o`, `fwd_addr_o` and `fwd_data_o` one clock later, with the same address and data.
- R3: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0xA0 in that order set protection, and `prot_on_o` is high on the clock after the third write. None of the three is forwarded.
- R4: With protection on, data writes are forwarded only after that three-write prefix has completed in the same window. The prefix authorises only the rest of its own window.
- R5: On the clock after `window_end_i`, `cycle_start_o` pulses if the window saw any write. `cycle_dummy_o` is high with it when no data byte of that window was forwarded.
- R6: A window that forwarded at least one data byte ends with `cycle_start_o` high and `cycle_dummy_o` low.
- R7: A write that does not match the expected step sends the matcher back to idle. That write is handled as ordinary data and is not re-tested as a first step.
- R8: The end of a window returns the matcher to idle, so a prefix split across two windows does not complete.
- R9: Asserting `rst_ni` does not change the protect bit.
- R10: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20 clear protection. None of the six is forwarded.
- R11: A write in the same clock as `window_end_i` belongs to the closing window: it is forwarded under the rules above, and it counts toward that window's `cycle_start_o` and `cycle_dummy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (protect bit excluded) |
| load_valid_i | input | 1 | One captured byte write this clock |
| load_addr_i | input | 16 | Captured write address |
| load_data_i | input | 8 | Captured write data |
| window_end_i | input | 1 | Load window closed by inactivity |
| fwd_valid_o | output | 1 | Data write passed to the program controller |
| fwd_addr_o | output | 16 | Forwarded address |
| fwd_data_o | output | 8 | Forwarded data |
| cycle_start_o | output | 1 | Busy cycle begins |
| cycle_dummy_o | output | 1 | Busy cycle stores nothing |
| prot_on_o | output | 1 | Protect bit |

## Verification
A write and the end of its window can arrive in the same clock. In that case the write forwarding and the window close must both act on the same byte. The bench provokes this in two ways: it sends an unprotected data byte with `window_end_i` high, and it sends an empty window close on its own. It then checks that the byte is forwarded, that the closing cycle is real, and that an empty window raises no cycle at all. The dummy-versus-real choice is also judged right after the unlock prefix and right after a prefix split by a timeout.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_D3   = 3'd3,
    ST_D4   = 3'd4,
    ST_D5   = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic consume;
    logic en_hit;
    logic dis_hit;
  } cmd_hit_t;

endpackage

// File: rtl/swp_cmd_match.sv
module swp_cmd_match
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 16'h2AAA,
  parameter logic [DATA_W-1:0] D_KEY1 = 8'hAA,
  parameter logic [DATA_W-1:0] D_KEY2 = 8'h55,
  parameter logic [DATA_W-1:0] D_EN   = 8'hA0,
  parameter logic [DATA_W-1:0] D_PRE  = 8'h80,
  parameter logic [DATA_W-1:0] D_DIS  = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_valid_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              window_end_i,
  output cmd_hit_t          hit_o
);

  seq_st_e st_q, st_d;
  cmd_hit_t hit;

  logic at_a, at_b;
  logic w_key1, w_key2, w_en, w_pre, w_dis;

  assign at_a   = (load_addr_i == ADDR_A);
  assign at_b   = (load_addr_i == ADDR_B);
  assign w_key1 = at_a && (load_data_i == D_KEY1);
  assign w_key2 = at_b && (load_data_i == D_KEY2);
  assign w_en   = at_a && (load_data_i == D_EN);
  assign w_pre  = at_a && (load_data_i == D_PRE);
  assign w_dis  = at_a && (load_data_i == D_DIS);

  always_comb begin
    hit     = '0;
    st_d    = st_q;
    if (load_valid_i) begin
      unique case (st_q)
        ST_IDLE: if (w_key1) begin hit.consume = 1'b1; st_d = ST_K1; end
        ST_K1:   if (w_key2) begin hit.consume = 1'b1; st_d = ST_K2; end
        ST_K2: begin
          if (w_en) begin
            hit.consume = 1'b1;
            hit.en_hit  = 1'b1;
            st_d        = ST_IDLE;
          end else if (w_pre) begin
            hit.consume = 1'b1;
            st_d        = ST_D3;
          end
        end
        ST_D3:   if (w_key1) begin hit.consume = 1'b1; st_d = ST_D4; end
        ST_D4:   if (w_key2) begin hit.consume = 1'b1; st_d = ST_D5; end
        ST_D5: begin
          if (w_dis) begin
            hit.consume = 1'b1;
            hit.dis_hit = 1'b1;
            st_d        = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      // any miss drops back to idle; the write stays data
      if (!hit.consume) st_d = ST_IDLE;
    end
    if (window_end_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign hit_o = hit;

  p_idle_after_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_end_i |=> (st_q == ST_IDLE));

  p_miss_to_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_i && !hit_o.consume) |=> (st_q == ST_IDLE));

  p_single_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o.en_hit && hit_o.dis_hit));

endmodule

// File: rtl/swp_fwd_stage.sv
module swp_fwd_stage #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= pass_i;
      if (pass_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  p_fwd_payload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i |=> (addr_o == $past(addr_i) && data_o == $past(data_i)));

endmodule

// File: rtl/swp_window_track.sv
module swp_window_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_valid_i,
  input  logic data_ok_i,
  input  logic window_end_i,
  output logic cycle_start_o,
  output logic cycle_dummy_o
);

  logic wr_seen_q, data_seen_q;
  logic start_q, dummy_q;
  logic any_wr, any_data;

  // a write in the closing clock still counts for this window
  assign any_wr   = wr_seen_q | load_valid_i;
  assign any_data = data_seen_q | data_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_seen_q   <= 1'b0;
      data_seen_q <= 1'b0;
      start_q     <= 1'b0;
      dummy_q     <= 1'b0;
    end else if (window_end_i) begin
      wr_seen_q   <= 1'b0;
      data_seen_q <= 1'b0;
      start_q     <= any_wr;
      dummy_q     <= any_wr & ~any_data;
    end else begin
      wr_seen_q   <= any_wr;
      data_seen_q <= any_data;
      start_q     <= 1'b0;
      dummy_q     <= 1'b0;
    end
  end

  assign cycle_start_o = start_q;
  assign cycle_dummy_o = dummy_q;

  p_dummy_in_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_dummy_o |-> cycle_start_o);

  p_start_after_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> $past(window_end_i));

  p_data_is_real_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_end_i && data_ok_i) |=> (cycle_start_o && !cycle_dummy_o));

endmodule

// File: rtl/swp_gate.sv
module swp_gate
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 16'h2AAA,
  parameter logic [DATA_W-1:0] D_KEY1 = 8'hAA,
  parameter logic [DATA_W-1:0] D_KEY2 = 8'h55,
  parameter logic [DATA_W-1:0] D_EN   = 8'hA0,
  parameter logic [DATA_W-1:0] D_PRE  = 8'h80,
  parameter logic [DATA_W-1:0] D_DIS  = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_valid_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              window_end_i,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o,
  output logic [DATA_W-1:0] fwd_data_o,
  output logic              cycle_start_o,
  output logic              cycle_dummy_o,
  output logic              prot_on_o
);

  cmd_hit_t cmd_hit;
  logic     auth_q;
  logic     allowed, data_ok;

  // models the nonvolatile cell: cleared at delivery, untouched by reset
  logic prot_q = 1'b0;

  swp_cmd_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_A(ADDR_A), .ADDR_B(ADDR_B),
    .D_KEY1(D_KEY1), .D_KEY2(D_KEY2),
    .D_EN(D_EN), .D_PRE(D_PRE), .D_DIS(D_DIS)
  ) u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_valid_i (load_valid_i),
    .load_addr_i  (load_addr_i),
    .load_data_i  (load_data_i),
    .window_end_i (window_end_i),
    .hit_o        (cmd_hit)
  );

  always_ff @(posedge clk_i) begin
    if (cmd_hit.en_hit)       prot_q <= 1'b1;
    else if (cmd_hit.dis_hit) prot_q <= 1'b0;
  end

  // prefix authorises the remainder of its own window only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             auth_q <= 1'b0;
    else if (window_end_i)   auth_q <= 1'b0;
    else if (cmd_hit.en_hit) auth_q <= 1'b1;
  end

  assign allowed = ~prot_q | auth_q;
  assign data_ok = load_valid_i & ~cmd_hit.consume & allowed;

  swp_fwd_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pass_i  (data_ok),
    .addr_i  (load_addr_i),
    .data_i  (load_data_i),
    .valid_o (fwd_valid_o),
    .addr_o  (fwd_addr_o),
    .data_o  (fwd_data_o)
  );

  swp_window_track u_win (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_valid_i  (load_valid_i),
    .data_ok_i     (data_ok),
    .window_end_i  (window_end_i),
    .cycle_start_o (cycle_start_o),
    .cycle_dummy_o (cycle_dummy_o)
  );

  assign prot_on_o = prot_q;

  p_prot_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit.en_hit |=> prot_on_o);

  p_prot_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit.dis_hit |=> !prot_on_o);

  p_cmd_not_fwd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_i && cmd_hit.consume) |=> !fwd_valid_o);

  p_locked_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_i && prot_q && !auth_q) |=> !fwd_valid_o);

  p_fwd_has_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(load_valid_i));

endmodule

// File: tb/tb_swp_gate.sv
`timescale 1ns/1ps
module tb_swp_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lv = 1'b0;
  logic [15:0] la = '0;
  logic [7:0]  ld = '0;
  logic        we = 1'b0;
  logic        fv;
  logic [15:0] fa;
  logic [7:0]  fd;
  logic        cs, cd, po;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  swp_gate dut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_valid_i(lv), .load_addr_i(la), .load_data_i(ld),
    .window_end_i(we),
    .fwd_valid_o(fv), .fwd_addr_o(fa), .fwd_data_o(fd),
    .cycle_start_o(cs), .cycle_dummy_o(cd), .prot_on_o(po)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d, input logic endw);
    @(negedge clk);
    lv = 1'b1; la = a; ld = d; we = endw;
    @(negedge clk);
    lv = 1'b0; we = 1'b0;
  endtask

  task automatic close_win();
    @(negedge clk);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 fwd in reset", {31'd0, fv}, 0);
    chk("R1 start in reset", {30'd0, cs, cd}, 0);
    chk("R1 prot at delivery", {31'd0, po}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 prot after reset", {31'd0, po}, 0);
  endtask

  task automatic t_unprot();
    put(16'h0123, 8'h3C, 1'b0);
    chk("R2 fwd valid", {31'd0, fv}, 1);
    chk("R2 fwd addr", {16'd0, fa}, 32'h0123);
    chk("R2 fwd data", {24'd0, fd}, 32'h3C);
    put(16'h0124, 8'hC3, 1'b0);
    chk("R2 second data", {24'd0, fd}, 32'hC3);
    close_win();
    chk("R6 real cycle", {30'd0, cs, cd}, 32'b10);
  endtask

  task automatic t_same_cycle();
    put(16'h0300, 8'h5A, 1'b1);
    chk("R11 fwd on end clk", {31'd0, fv}, 1);
    chk("R11 addr", {16'd0, fa}, 32'h0300);
    chk("R11 real cycle", {30'd0, cs, cd}, 32'b10);
    close_win();
    chk("R5 empty window no cycle", {30'd0, cs, cd}, 0);
  endtask

  task automatic enable_seq(input logic endlast);
    put(16'h5555, 8'hAA, 1'b0);
    chk("R3 step1 not fwd", {31'd0, fv}, 0);
    put(16'h2AAA, 8'h55, 1'b0);
    chk("R3 step2 not fwd", {31'd0, fv}, 0);
    put(16'h5555, 8'hA0, endlast);
    chk("R3 step3 not fwd", {31'd0, fv}, 0);
  endtask

  task automatic t_enable();
    enable_seq(1'b0);
    chk("R3 prot set", {31'd0, po}, 1);
    put(16'h0400, 8'h11, 1'b0);
    chk("R4 prefixed fwd", {31'd0, fv}, 1);
    chk("R4 prefixed data", {24'd0, fd}, 32'h11);
    close_win();
    chk("R6 prefixed real", {30'd0, cs, cd}, 32'b10);
  endtask

  task automatic t_locked();
    put(16'h0500, 8'h22, 1'b0);
    chk("R4 unprefixed held", {31'd0, fv}, 0);
    put(16'h0501, 8'h23, 1'b0);
    chk("R4 unprefixed held 2", {31'd0, fv}, 0);
    close_win();
    chk("R5 dummy cycle", {30'd0, cs, cd}, 32'b11);
    chk("R4 prot kept", {31'd0, po}, 1);
    enable_seq(1'b0);
    put(16'h0600, 8'h44, 1'b0);
    chk("R4 re-prefixed fwd", {31'd0, fv}, 1);
    close_win();
    put(16'h0601, 8'h45, 1'b0);
    chk("R4 auth not carried", {31'd0, fv}, 0);
    close_win();
    chk("R5 next window dummy", {30'd0, cs, cd}, 32'b11);
  endtask

  task automatic t_timeout();
    put(16'h5555, 8'hAA, 1'b0);
    put(16'h2AAA, 8'h55, 1'b1);
    chk("R5 cmd-only window dummy", {30'd0, cs, cd}, 32'b11);
    put(16'h5555, 8'hA0, 1'b0);
    chk("R8 split prefix not fwd", {31'd0, fv}, 0);
    put(16'h0700, 8'h66, 1'b0);
    chk("R8 split prefix no auth", {31'd0, fv}, 0);
    close_win();
    chk("R8 dummy after split", {30'd0, cs, cd}, 32'b11);
  endtask

  task automatic t_reset_keeps();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 prot in reset", {31'd0, po}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 prot after reset", {31'd0, po}, 1);
  endtask

  task automatic t_disable();
    put(16'h5555, 8'hAA, 1'b0);
    put(16'h2AAA, 8'h55, 1'b0);
    put(16'h5555, 8'h80, 1'b0);
    chk("R10 step3 not fwd", {31'd0, fv}, 0);
    put(16'h5555, 8'hAA, 1'b0);
    put(16'h2AAA, 8'h55, 1'b0);
    chk("R10 prot still on", {31'd0, po}, 1);
    put(16'h5555, 8'h20, 1'b0);
    chk("R10 last not fwd", {31'd0, fv}, 0);
    chk("R10 prot cleared", {31'd0, po}, 0);
    put(16'h0800, 8'h77, 1'b0);
    chk("R10 data fwd after clear", {31'd0, fv}, 1);
    close_win();
    chk("R10 real cycle", {30'd0, cs, cd}, 32'b10);
  endtask

  task automatic t_mismatch();
    put(16'h5555, 8'hAA, 1'b0);
    chk("R7 step1 swallowed", {31'd0, fv}, 0);
    put(16'h2AAA, 8'h33, 1'b0);
    chk("R7 miss is data", {31'd0, fv}, 1);
    chk("R7 miss addr", {16'd0, fa}, 32'h2AAA);
    chk("R7 miss data", {24'd0, fd}, 32'h33);
    put(16'h5555, 8'hA0, 1'b0);
    chk("R7 idle after miss", {31'd0, fv}, 1);
    chk("R7 no enable", {31'd0, po}, 0);
    close_win();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_unprot();
    t_same_cycle();
    t_enable();
    t_locked();
    t_timeout();
    t_reset_keeps();
    t_disable();
    t_mismatch();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule